// File: doc/BRIEF.md
# Latched Byte-Scanning Output Sequencer

This block sits behind a binary counter. It keeps a snapshot of the count in a holding register and presents that snapshot one byte at a time on an 8-bit output bus. The bus is modelled as a data vector plus a drive-enable, so the pad-level three-state buffer can sit outside the block. A single active-low line does two jobs. While it is low, the block copies the live count into the holding register and returns the byte pointer to the first byte. When the line goes high, the snapshot is frozen. A scan enable then lets each rising edge of the scan clock move the presented byte forward by one.

After the most significant byte has been shown, the next step releases the bus and raises a cascade output. This output stays high until the next load. If that output drives the scan enable of a second copy, the two copies put their bytes on one shared bus back to back, with no gap. A parameter adds a fifth byte, taken from an external prescaler. That byte takes the lowest position and is presented first.

The controller is a four-state machine:
- IDLE is entered at reset. It floats the bus and waits for the load line.
- LOAD captures the count while the load line is low.
- SCAN presents bytes.
- DONE floats the bus and asserts cascade.

The transitions are:
- any state to LOAD whenever the load line is low at a clock edge;
- LOAD to SCAN at the first edge with the load line high (pointer at byte 0);
- SCAN to SCAN with the pointer plus one on an enabled edge below the last byte;
- SCAN to DONE on an enabled edge at the last byte.

Top module: `byte_scan_seq`

## Requirements
- R1: While reset is asserted, bus_oe_o and casc_o are 0.
- R2: Each rising edge of scan_clk with load_n low copies the inputs into the snapshot. Input changes after load_n returns high do not alter any byte later presented.
- R3: A low load_n forces bus_oe_o to 0 in the same cycle. The first edge that samples load_n low clears casc_o and returns the pointer to byte 0. This holds in every state, including partway through a scan.
- R4: After a load, the first edge with load_n high enters SCAN at byte 0, and no byte is driven before that edge. Byte k is snapshot bits [8k+7:8k], presented in order from k = 0 upward.
- R5: In SCAN, bus_oe_o equals scan_en. The pointer advances by exactly one byte on each rising edge that samples scan_en high, and holds on edges that sample it low.
- R6: The enabled edge at the last byte moves to DONE. In DONE, bus_oe_o is 0 and casc_o is 1 whatever scan_en does, until load_n is low at an edge.
- R7: With HAS_PRE=1 the snapshot is {count_i, pre_i}, so 5 bytes are presented: pre_i first, then the count's bytes from least to most significant.
- R8: With two copies sharing load_n, where the second's scan_en is the first's casc_o and the first's scan_en is held high, the bus carries the first copy's 4 bytes and then the second copy's 4 bytes. The bytes come on consecutive cycles, and exactly one copy drives in each of those cycles.
- R9: After reset and before the first load, bus_oe_o and casc_o stay 0 regardless of scan_en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| scan_clk | input | 1 | Scan clock; every state change happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_n | input | 1 | Active low: snapshot load and scan restart |
| scan_en | input | 1 | Active high: permits drive and pointer advance |
| count_i | input | CNT_W (32) | Live counter value |
| pre_i | input | PRE_W (8) | Prescaler byte, used only when HAS_PRE=1 |
| bus_o | output | BYTE_W (8) | Presented byte, zero while not driving |
| bus_oe_o | output | 1 | Drive enable for the shared bus |
| casc_o | output | 1 | Cascade enable for the next copy in a chain |

## Verification
A pointer that skips or repeats a step shows up as a wrong or duplicated byte value in the very next scan cycle. A stuck or early DONE state shows up as a missing byte or a premature cascade. In a chain, that cascade fault appears as two drivers at once or a one-cycle gap on the shared bus. A snapshot that is not frozen shows up as byte values that follow the scrambled live count during the scan. The sweeps load many arithmetic count patterns into a two-copy chain and into a five-byte copy. Every presented byte is compared in the cycle it is expected, so any such fault is seen within one scan clock of its cause.

// File: rtl/bsq_pkg.sv
`timescale 1ns/1ps
package bsq_pkg;

    typedef enum logic [1:0] {
        BSQ_IDLE = 2'd0,
        BSQ_LOAD = 2'd1,
        BSQ_SCAN = 2'd2,
        BSQ_DONE = 2'd3
    } bsq_state_e;

    function automatic int bsq_ptr_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/bsq_snap.sv
`timescale 1ns/1ps
module bsq_snap #(
    parameter int CNT_W   = 32,
    parameter int PRE_W   = 8,
    parameter bit HAS_PRE = 1'b0,
    localparam int TOT_W  = CNT_W + (HAS_PRE ? PRE_W : 0)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic [PRE_W-1:0] pre_i,
    output logic [TOT_W-1:0] snap_o
);

    logic [TOT_W-1:0] live_w;
    logic [TOT_W-1:0] snap_q;

    generate
        if (HAS_PRE) begin : g_with_pre
            assign live_w = {count_i, pre_i};
        end else begin : g_no_pre
            logic unused_pre;
            assign unused_pre = ^pre_i;
            assign live_w     = count_i;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (!load_n) begin
            snap_q <= live_w;
        end
    end

    assign snap_o = snap_q;

    // R2: once the load line is high the snapshot must not move
    p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_n |=> $stable(snap_q));

endmodule

// File: rtl/bsq_bytesel.sv
`timescale 1ns/1ps
module bsq_bytesel #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 4,
    parameter int PTR_W  = 2,
    localparam int TOT_W = BYTE_W * NBYTES
) (
    input  logic [TOT_W-1:0]  snap_i,
    input  logic [PTR_W-1:0]  ptr_i,
    output logic [BYTE_W-1:0] byte_o
);

    logic [BYTE_W-1:0] lane [NBYTES];

    generate
        for (genvar g = 0; g < NBYTES; g++) begin : g_lane
            assign lane[g] = snap_i[g*BYTE_W +: BYTE_W];
        end
    endgenerate

    always_comb begin
        byte_o = lane[0];
        for (int i = 1; i < NBYTES; i++) begin
            if (ptr_i == PTR_W'(i)) begin
                byte_o = lane[i];
            end
        end
    end

endmodule

// File: rtl/bsq_fsm.sv
`timescale 1ns/1ps
module bsq_fsm
    import bsq_pkg::*;
#(
    parameter int NBYTES = 4,
    parameter int PTR_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             scan_en,
    output logic [PTR_W-1:0] ptr_o,
    output logic             drive_o,
    output logic             casc_o
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(NBYTES - 1);

    bsq_state_e       state_q, state_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        if (!load_n) begin
            state_d = BSQ_LOAD;
            ptr_d   = '0;
        end else begin
            unique case (state_q)
                BSQ_IDLE: begin
                    state_d = BSQ_IDLE;
                end
                BSQ_LOAD: begin
                    state_d = BSQ_SCAN;
                    ptr_d   = '0;
                end
                BSQ_SCAN: begin
                    if (scan_en) begin
                        if (ptr_q == LAST) begin
                            state_d = BSQ_DONE;
                        end else begin
                            ptr_d = ptr_q + 1'b1;
                        end
                    end
                end
                BSQ_DONE: begin
                    state_d = BSQ_DONE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BSQ_IDLE;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    // outputs
    always_comb begin
        drive_o = 1'b0;
        casc_o  = 1'b0;
        unique case (state_q)
            BSQ_IDLE: ;
            BSQ_LOAD: ;
            BSQ_SCAN: drive_o = scan_en & load_n;
            BSQ_DONE: casc_o  = 1'b1;
        endcase
    end

    assign ptr_o = ptr_q;

    p_load_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> (ptr_q == '0 && !casc_o));

    p_ptr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (ptr_q <= LAST));

    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BSQ_SCAN && load_n && scan_en && ptr_q != LAST)
        |=> (ptr_q == $past(ptr_q) + 1'b1));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BSQ_SCAN && load_n && !scan_en) |=> $stable(ptr_q));

    p_last_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BSQ_SCAN && load_n && scan_en && ptr_q == LAST) |=> casc_o);

    p_casc_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (casc_o && load_n) |=> casc_o);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BSQ_IDLE && load_n) |=> (!drive_o && !casc_o));

endmodule

// File: rtl/byte_scan_seq.sv
`timescale 1ns/1ps
module byte_scan_seq
    import bsq_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int PRE_W   = 8,
    parameter bit HAS_PRE = 1'b0,
    parameter int BYTE_W  = 8
) (
    input  logic              scan_clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              scan_en,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [PRE_W-1:0]  pre_i,
    output logic [BYTE_W-1:0] bus_o,
    output logic              bus_oe_o,
    output logic              casc_o
);

    localparam int TOT_W  = CNT_W + (HAS_PRE ? PRE_W : 0);
    localparam int NBYTES = TOT_W / BYTE_W;
    localparam int PTR_W  = bsq_ptr_bits(NBYTES);

    logic [TOT_W-1:0]  snap_w;
    logic [PTR_W-1:0]  ptr_w;
    logic [BYTE_W-1:0] sel_w;
    logic              drive_w;

    bsq_snap #(
        .CNT_W   (CNT_W),
        .PRE_W   (PRE_W),
        .HAS_PRE (HAS_PRE)
    ) i_snap (
        .clk     (scan_clk),
        .rst_n   (rst_n),
        .load_n  (load_n),
        .count_i (count_i),
        .pre_i   (pre_i),
        .snap_o  (snap_w)
    );

    bsq_fsm #(
        .NBYTES (NBYTES),
        .PTR_W  (PTR_W)
    ) i_fsm (
        .clk     (scan_clk),
        .rst_n   (rst_n),
        .load_n  (load_n),
        .scan_en (scan_en),
        .ptr_o   (ptr_w),
        .drive_o (drive_w),
        .casc_o  (casc_o)
    );

    bsq_bytesel #(
        .BYTE_W (BYTE_W),
        .NBYTES (NBYTES),
        .PTR_W  (PTR_W)
    ) i_sel (
        .snap_i (snap_w),
        .ptr_i  (ptr_w),
        .byte_o (sel_w)
    );

    assign bus_oe_o = drive_w;
    assign bus_o    = drive_w ? sel_w : '0;

    p_casc_no_drive_r6: assert property (@(posedge scan_clk) disable iff (!rst_n)
        casc_o |-> !bus_oe_o);

    p_load_float_r3: assert property (@(posedge scan_clk) disable iff (!rst_n)
        (!load_n && !$past(load_n)) |-> !bus_oe_o);

endmodule

// File: tb/test_byte_scan_seq.sv
`timescale 1ns/1ps
module test_byte_scan_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ld_n, sen_a;
    logic [31:0] cnt_a, cnt_b;
    logic [7:0]  pre_z;
    logic [7:0]  bus_a, bus_b, bus_w;
    logic        oe_a, oe_b, oe_w, casc_a, casc_b, casc_w;
    logic        ld_w, sen_w;
    logic [31:0] cnt_w;
    logic [7:0]  pre_w;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    byte_scan_seq #(.HAS_PRE(1'b0)) i_byte_scan_seq (
        .scan_clk(clk), .rst_n(rst_n), .load_n(ld_n), .scan_en(sen_a),
        .count_i(cnt_a), .pre_i(pre_z),
        .bus_o(bus_a), .bus_oe_o(oe_a), .casc_o(casc_a));

    byte_scan_seq #(.HAS_PRE(1'b0)) i_byte_scan_seq_b (
        .scan_clk(clk), .rst_n(rst_n), .load_n(ld_n), .scan_en(casc_a),
        .count_i(cnt_b), .pre_i(pre_z),
        .bus_o(bus_b), .bus_oe_o(oe_b), .casc_o(casc_b));

    byte_scan_seq #(.HAS_PRE(1'b1)) i_byte_scan_seq_w (
        .scan_clk(clk), .rst_n(rst_n), .load_n(ld_w), .scan_en(sen_w),
        .count_i(cnt_w), .pre_i(pre_w),
        .bus_o(bus_w), .bus_oe_o(oe_w), .casc_o(casc_w));

    function automatic logic [7:0] byte_of(input logic [31:0] v, input int k);
        return 8'((v >> (8 * k)) & 32'hFF);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic settle;
        #1;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // two-copy chain: load, then 8 contiguous bytes
    task automatic run_chain(input logic [31:0] v, input logic [31:0] w);
        tick; ld_n = 1'b0; sen_a = 1'b1; cnt_a = ~v; cnt_b = ~w; settle;
        chk("R3 float during load", {30'd0, oe_a, oe_b}, 32'd0);
        tick; cnt_a = v; cnt_b = w; settle;
        chk("R3 cascade cleared by load", {30'd0, casc_a, casc_b}, 32'd0);
        tick; ld_n = 1'b1; cnt_a = v ^ 32'h5A5A_5A5A; cnt_b = w + 32'h1357_9BDF; settle;
        chk("R4 no drive before scan", {30'd0, oe_a, oe_b}, 32'd0);
        for (int k = 0; k < 8; k++) begin
            tick; cnt_a = cnt_a + 32'h0101_0101; cnt_b = cnt_b ^ 32'hFFFF_0000; settle;
            chk("R8 single driver", 32'(oe_a) + 32'(oe_b), 32'd1);
            chk("R4 R8 byte order", {24'd0, (oe_a ? bus_a : bus_b)},
                {24'd0, (k < 4) ? byte_of(v, k) : byte_of(w, k - 4)});
            chk("R6 cascade timing", {31'd0, casc_a}, {31'd0, (k >= 4)});
        end
        tick; settle;
        chk("R6 chain done", {29'd0, oe_a, oe_b, casc_b}, 32'd1);
    endtask

    // five-byte copy, optional pause and optional early abort
    task automatic run_wide(input logic [31:0] c, input logic [7:0] p,
                            input int pause_at, input int stop_at);
        tick; ld_w = 1'b0; sen_w = 1'b1; cnt_w = c + 32'd7; pre_w = ~p; settle;
        chk("R3 wide float on load", {31'd0, oe_w}, 32'd0);
        tick; cnt_w = c; pre_w = p; settle;
        chk("R3 wide cascade cleared", {31'd0, casc_w}, 32'd0);
        tick; ld_w = 1'b1; cnt_w = ~c; pre_w = p + 8'd3; settle;
        chk("R4 wide no early drive", {31'd0, oe_w}, 32'd0);
        for (int k = 0; k < 5; k++) begin
            if (k == stop_at) return;
            if (k == pause_at) begin
                tick; sen_w = 1'b0; cnt_w = cnt_w * 32'd3 + 32'd1; settle;
                chk("R5 paused no drive", {31'd0, oe_w}, 32'd0);
                tick; sen_w = 1'b1; settle;
            end else begin
                tick; cnt_w = cnt_w + 32'h0F0F_0F0F; pre_w = pre_w ^ 8'hA5; settle;
            end
            chk("R5 wide driving", {31'd0, oe_w}, 32'd1);
            chk("R7 R2 wide byte", {24'd0, bus_w},
                {24'd0, (k == 0) ? p : byte_of(c, k - 1)});
        end
        for (int j = 0; j < 3; j++) begin
            tick; sen_w = j[0]; settle;
            chk("R6 done sticky", {30'd0, oe_w, casc_w}, 32'd1);
        end
        sen_w = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        summary;
    end

    initial begin
        rst_n = 1'b0; ld_n = 1'b1; sen_a = 1'b0; cnt_a = '0; cnt_b = '0; pre_z = '0;
        ld_w = 1'b1; sen_w = 1'b0; cnt_w = '0; pre_w = '0;
        repeat (3) tick;
        chk("R1 reset outputs", {26'd0, oe_a, oe_b, oe_w, casc_a, casc_b, casc_w}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        sen_a = 1'b1; sen_w = 1'b1; cnt_a = 32'h1234_5678; cnt_w = 32'h8765_4321;
        for (int i = 0; i < 4; i++) begin
            tick; settle;
            chk("R9 idle quiet", {26'd0, oe_a, oe_b, oe_w, casc_a, casc_b, casc_w}, 32'd0);
        end
        run_chain(32'h0000_0000, 32'hFFFF_FFFF);
        run_chain(32'hFFFF_FFFF, 32'h0000_0000);
        for (int i = 0; i < 16; i++) begin
            run_chain(32'h0403_0201 * 32'(i + 1) ^ (32'(i) << 28),
                      32'h1111_1111 * 32'(i) + 32'h89AB_CDEF);
        end
        for (int i = 0; i < 10; i++) begin
            run_wide(32'hC0DE_0000 + 32'h0102_0304 * 32'(i), 8'(8'h10 + 8'(i * 17)), i % 6, 9);
        end
        // R3 reload partway through a scan, then a full clean scan
        run_wide(32'hDEAD_BEEF, 8'h42, 9, 2);
        run_wide(32'h0BAD_F00D, 8'h99, 9, 9);
        run_wide(32'h7654_3210, 8'hE1, 9, 4);
        run_wide(32'h0F1E_2D3C, 8'h5B, 3, 9);
        summary;
    end

endmodule